// File: doc/BRIEF.md
# Operand Bypass and Load-Use Interlock Unit

This unit is the hazard-control logic for a five-stage in-order integer pipeline (fetch, decode, execute, memory access, writeback). Each cycle it compares the two source register indices of the instruction entering execute with the destination indices held in the two later pipeline registers. From that comparison it chooses, for each ALU operand, whether the value comes from the register file, from the execute/memory result or from the memory/writeback result.

The unit also watches for a load in execute whose destination is read by the instruction now in decode. Bypassing cannot cover that case, because load data only exists at the end of the memory stage. When it occurs, the unit raises a stall. The stall holds the program counter and the fetch/decode register, and it clears the control bits written into the decode/execute register, so a no-op bubble moves down the pipe. One cycle later the loaded value is bypassed from the memory/writeback stage.

Every output is a combinational function of the current pipeline register fields. The register index width is a parameter.

Top module: `pipe_hazard_ctrl`

## Requirements
- R1: `fwd_a_o` selects the source for ALU operand A by comparing `idex_rs_i` with `exmem_rd_i` and `memwb_rd_i`.
- R2: `fwd_b_o` selects the source for ALU operand B by comparing `idex_rt_i` with the same two destination indices.
- R3: A destination is a match only while the `_we_i` flag of its stage is 1. With the flag at 0, equal indices leave the select at 0.
- R4: A destination index of 0 never produces a select other than 0.
- R5: The select encoding is 0 for the register file, 1 for the execute/memory result and 2 for the memory/writeback result. The value 3 never appears.
- R6: When both later stages match the same source, the select is 1, because the execute/memory stage holds the newer value.
- R7: `stall_o` is 1 exactly when all of these hold: `idex_memread_i` is 1, `idex_rt_i` is nonzero, and `idex_rt_i` equals `ifid_rs_i` or `ifid_rt_i`. An ALU result used by the next instruction therefore costs no stall. A load-use pair costs exactly one stall cycle, after which the load value is selected with code 2.
- R8: While `stall_o` is 1, `pc_we_o` and `ifid_we_o` are 0 and `idex_bubble_o` is 1. Otherwise `pc_we_o` and `ifid_we_o` are 1 and `idex_bubble_o` is 0.
- R9: A load whose destination is 0 never stalls. An instruction that is not a load never stalls, whatever its indices are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| idex_rs_i | input | REG_W | First source index of the instruction in execute |
| idex_rt_i | input | REG_W | Second source index in execute (the destination when it is a load) |
| idex_memread_i | input | 1 | Instruction in execute is a load |
| exmem_rd_i | input | REG_W | Destination index in the execute/memory register |
| exmem_we_i | input | 1 | Register write enable of the execute/memory stage |
| memwb_rd_i | input | REG_W | Destination index in the memory/writeback register |
| memwb_we_i | input | 1 | Register write enable of the memory/writeback stage |
| ifid_rs_i | input | REG_W | First source index of the instruction in decode |
| ifid_rt_i | input | REG_W | Second source index of the instruction in decode |
| fwd_a_o | output | 2 | Operand A select (0 regfile, 1 exmem, 2 memwb) |
| fwd_b_o | output | 2 | Operand B select (same encoding) |
| stall_o | output | 1 | Load-use interlock active |
| pc_we_o | output | 1 | Program counter write enable |
| ifid_we_o | output | 1 | Fetch/decode register write enable |
| idex_bubble_o | output | 1 | Clear control bits written into decode/execute |

## Verification
A behavioural pipeline in the bench runs short programs through the unit. Back-to-back ALU dependencies and dependencies at distance two separate select code 1 from code 2, and they also check that operand B is handled apart from operand A. A doubly written register shows whether the newer stage wins. Load-use pairs, on the first source and on the second, confirm exactly one bubble followed by a code-2 bypass. A load at distance two must bypass without stalling. Writes to register 0, and instructions whose write enable is off, must not trigger any bypass or stall, even though their indices match.

// File: rtl/hazard_pkg.sv
package hazard_pkg;
  typedef enum logic [1:0] {
    FWD_REG   = 2'd0,
    FWD_EXMEM = 2'd1,
    FWD_MEMWB = 2'd2
  } fwd_sel_e;

  localparam int unsigned NUM_OPS = 2;
endpackage

// File: rtl/hz_fwd_sel.sv
module hz_fwd_sel
  import hazard_pkg::*;
#(
  parameter int unsigned REG_W = 5
) (
  input  logic [REG_W-1:0] src_i,
  input  logic [REG_W-1:0] exmem_rd_i,
  input  logic             exmem_we_i,
  input  logic [REG_W-1:0] memwb_rd_i,
  input  logic             memwb_we_i,
  output fwd_sel_e         sel_o
);
  localparam logic [REG_W-1:0] ZERO_REG = '0;

  logic hit_exmem, hit_memwb;

  assign hit_exmem = exmem_we_i && (exmem_rd_i != ZERO_REG) && (exmem_rd_i == src_i);
  assign hit_memwb = memwb_we_i && (memwb_rd_i != ZERO_REG) && (memwb_rd_i == src_i);

  // newer stage first
  always_comb begin
    if (hit_exmem)      sel_o = FWD_EXMEM;
    else if (hit_memwb) sel_o = FWD_MEMWB;
    else                sel_o = FWD_REG;
  end

  always_comb begin
    if (sel_o == FWD_EXMEM)
      p_exmem_gated_r3: assert (exmem_we_i && exmem_rd_i == src_i);
    if (sel_o == FWD_MEMWB)
      p_memwb_gated_r3: assert (memwb_we_i && memwb_rd_i == src_i && !(exmem_we_i && exmem_rd_i == src_i && src_i != ZERO_REG));
    if (src_i == ZERO_REG)
      p_zero_src_r4: assert (sel_o == FWD_REG);
    p_sel_legal_r5: assert (sel_o != fwd_sel_e'(2'd3));
  end
endmodule

// File: rtl/hz_load_use.sv
module hz_load_use #(
  parameter int unsigned REG_W = 5
) (
  input  logic             idex_memread_i,
  input  logic [REG_W-1:0] idex_rt_i,
  input  logic [REG_W-1:0] ifid_rs_i,
  input  logic [REG_W-1:0] ifid_rt_i,
  output logic             stall_o
);
  localparam logic [REG_W-1:0] ZERO_REG = '0;

  logic dep_rs, dep_rt;

  assign dep_rs  = (idex_rt_i == ifid_rs_i);
  assign dep_rt  = (idex_rt_i == ifid_rt_i);
  assign stall_o = idex_memread_i && (idex_rt_i != ZERO_REG) && (dep_rs || dep_rt);

  always_comb begin
    if (!idex_memread_i)
      p_no_load_no_stall_r9: assert (!stall_o);
    if (idex_rt_i == ZERO_REG)
      p_zero_dst_no_stall_r9: assert (!stall_o);
    if (stall_o)
      p_stall_has_dep_r7: assert (idex_rt_i == ifid_rs_i || idex_rt_i == ifid_rt_i);
  end
endmodule

// File: rtl/pipe_hazard_ctrl.sv
module pipe_hazard_ctrl
  import hazard_pkg::*;
#(
  parameter int unsigned REG_W = 5
) (
  input  logic [REG_W-1:0] idex_rs_i,
  input  logic [REG_W-1:0] idex_rt_i,
  input  logic             idex_memread_i,
  input  logic [REG_W-1:0] exmem_rd_i,
  input  logic             exmem_we_i,
  input  logic [REG_W-1:0] memwb_rd_i,
  input  logic             memwb_we_i,
  input  logic [REG_W-1:0] ifid_rs_i,
  input  logic [REG_W-1:0] ifid_rt_i,
  output logic [1:0]       fwd_a_o,
  output logic [1:0]       fwd_b_o,
  output logic             stall_o,
  output logic             pc_we_o,
  output logic             ifid_we_o,
  output logic             idex_bubble_o
);
  logic [REG_W-1:0] op_src [NUM_OPS];
  fwd_sel_e         op_sel [NUM_OPS];
  logic             stall;

  assign op_src[0] = idex_rs_i;
  assign op_src[1] = idex_rt_i;

  for (genvar g = 0; g < NUM_OPS; g++) begin : g_op
    hz_fwd_sel #(.REG_W(REG_W)) u_sel (
      .src_i      (op_src[g]),
      .exmem_rd_i (exmem_rd_i),
      .exmem_we_i (exmem_we_i),
      .memwb_rd_i (memwb_rd_i),
      .memwb_we_i (memwb_we_i),
      .sel_o      (op_sel[g])
    );
  end

  hz_load_use #(.REG_W(REG_W)) u_lu (
    .idex_memread_i (idex_memread_i),
    .idex_rt_i      (idex_rt_i),
    .ifid_rs_i      (ifid_rs_i),
    .ifid_rt_i      (ifid_rt_i),
    .stall_o        (stall)
  );

  assign fwd_a_o       = op_sel[0];
  assign fwd_b_o       = op_sel[1];
  assign stall_o       = stall;
  assign pc_we_o       = !stall;
  assign ifid_we_o     = !stall;
  assign idex_bubble_o = stall;

  always_comb begin
    if (stall_o)
      p_freeze_on_stall_r8: assert (!pc_we_o && !ifid_we_o && idex_bubble_o);
    if (exmem_we_i && exmem_rd_i != '0 && exmem_rd_i == idex_rs_i)
      p_exmem_wins_a_r6: assert (fwd_a_o == 2'd1);
    if (exmem_we_i && exmem_rd_i != '0 && exmem_rd_i == idex_rt_i)
      p_exmem_wins_b_r6: assert (fwd_b_o == 2'd1);
  end
endmodule

// File: tb/pipe_hazard_ctrl_tb_top.sv
module pipe_hazard_ctrl_tb_top;
  typedef struct packed {
    logic       ld;
    logic       wr;
    logic [4:0] rd;
    logic [4:0] rs;
    logic [4:0] rt;
  } ins_t;

  localparam ins_t NOP = '0;
  localparam int PLEN = 8;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  int checks = 0, failures = 0;
  ins_t prog [PLEN];
  ins_t ifid, idex, exmem, memwb;
  int pc;

  logic [1:0] fwd_a, fwd_b;
  logic stall, pc_we, ifid_we, bubble;

  pipe_hazard_ctrl #(.REG_W(5)) dut_i (
    .idex_rs_i      (idex.rs),
    .idex_rt_i      (idex.rt),
    .idex_memread_i (idex.ld),
    .exmem_rd_i     (exmem.rd),
    .exmem_we_i     (exmem.wr),
    .memwb_rd_i     (memwb.rd),
    .memwb_we_i     (memwb.wr),
    .ifid_rs_i      (ifid.rs),
    .ifid_rt_i      (ifid.rt),
    .fwd_a_o        (fwd_a),
    .fwd_b_o        (fwd_b),
    .stall_o        (stall),
    .pc_we_o        (pc_we),
    .ifid_we_o      (ifid_we),
    .idex_bubble_o  (bubble)
  );

  function automatic ins_t alu(input int d, input int s, input int t);
    return '{ld: 1'b0, wr: 1'b1, rd: 5'(d), rs: 5'(s), rt: 5'(t)};
  endfunction
  function automatic ins_t lw(input int d, input int base);
    return '{ld: 1'b1, wr: 1'b1, rd: 5'(d), rs: 5'(base), rt: 5'(d)};
  endfunction
  function automatic ins_t nowr(input int d, input int s, input int t);
    return '{ld: 1'b0, wr: 1'b0, rd: 5'(d), rs: 5'(s), rt: 5'(t)};
  endfunction

  // reference select from the requirement text
  function automatic logic [1:0] ref_sel(input logic [4:0] src);
    if (exmem.wr && exmem.rd != 0 && exmem.rd == src) return 2'd1;
    if (memwb.wr && memwb.rd != 0 && memwb.rd == src) return 2'd2;
    return 2'd0;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_pipe();
    ifid = NOP; idex = NOP; exmem = NOP; memwb = NOP; pc = 0;
    for (int i = 0; i < PLEN; i++) prog[i] = NOP;
  endtask

  task automatic run_seq(input string tag, input int exp_stalls,
                         input int ea1, input int ea2, input int eb1, input int eb2);
    int n_st = 0, a1 = 0, a2 = 0, b1 = 0, b2 = 0;
    logic st_ref;
    for (int c = 0; c < 14; c++) begin
      @(negedge clk);
      st_ref = idex.ld && idex.rt != 0 && (idex.rt == ifid.rs || idex.rt == ifid.rt);
      chk({tag, " R1,R6 fwd_a"}, fwd_a, ref_sel(idex.rs));
      chk({tag, " R2,R6 fwd_b"}, fwd_b, ref_sel(idex.rt));
      chk({tag, " R7 stall"}, stall, st_ref);
      chk({tag, " R8 pc_we"}, pc_we, !st_ref);
      chk({tag, " R8 ifid_we"}, ifid_we, !st_ref);
      chk({tag, " R8 bubble"}, bubble, st_ref);
      if (stall) n_st++;
      if (fwd_a == 2'd1) a1++;
      if (fwd_a == 2'd2) a2++;
      if (fwd_b == 2'd1) b1++;
      if (fwd_b == 2'd2) b2++;
      if (fwd_a == 2'd3 || fwd_b == 2'd3) chk({tag, " R5 legal"}, 3, 0);
      @(posedge clk);
      memwb = exmem;
      exmem = idex;
      if (st_ref) idex = NOP;
      else begin
        idex = ifid;
        ifid = (pc < PLEN) ? prog[pc] : NOP;
        pc++;
      end
    end
    chk({tag, " R7 stall cycles"}, n_st, exp_stalls);
    chk({tag, " R5 sel1 count A"}, a1, ea1);
    chk({tag, " R5 sel2 count A"}, a2, ea2);
    chk({tag, " R5 sel1 count B"}, b1, eb1);
    chk({tag, " R5 sel2 count B"}, b2, eb2);
  endtask

  initial begin
    #(4 * 150000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    clear_pipe();
    @(negedge clk);
    chk("reset R5 fwd_a", fwd_a, 0);
    chk("reset R5 fwd_b", fwd_b, 0);
    chk("reset R7 stall", stall, 0);
    chk("reset R8 pc_we", pc_we, 1);

    clear_pipe(); prog[0] = alu(1, 2, 3); prog[1] = alu(4, 1, 5);
    run_seq("alu_alu R1", 0, 1, 0, 0, 0);

    clear_pipe(); prog[0] = alu(1, 2, 3); prog[1] = alu(6, 7, 8); prog[2] = alu(4, 5, 1);
    run_seq("dist2 R2", 0, 0, 0, 0, 1);

    clear_pipe(); prog[0] = alu(1, 2, 3); prog[1] = alu(1, 1, 5); prog[2] = alu(4, 1, 9);
    run_seq("double R6", 0, 2, 0, 0, 0);

    clear_pipe(); prog[0] = lw(1, 2); prog[1] = alu(3, 1, 4);
    run_seq("loaduse_rs R7", 1, 0, 1, 0, 0);

    clear_pipe(); prog[0] = lw(5, 2); prog[1] = alu(3, 4, 5);
    run_seq("loaduse_rt R7", 1, 0, 0, 0, 1);

    clear_pipe(); prog[0] = lw(1, 2); prog[1] = alu(6, 7, 8); prog[2] = alu(3, 1, 4);
    run_seq("load_dist2 R7", 0, 0, 1, 0, 0);

    clear_pipe(); prog[0] = alu(0, 2, 3); prog[1] = alu(4, 0, 0); prog[2] = lw(0, 2); prog[3] = alu(5, 0, 0);
    run_seq("zero_reg R4,R9", 0, 0, 0, 0, 0);

    clear_pipe(); prog[0] = nowr(1, 2, 1); prog[1] = alu(4, 1, 1); prog[2] = nowr(7, 7, 7); prog[3] = alu(6, 7, 8);
    run_seq("no_write R3,R9", 0, 0, 0, 0, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule